// File: doc/BRIEF.md
# Instruction Fetch Cache with Staging Line Buffer

This block sits between a processor's instruction fetch port and external memory. It holds a direct-mapped store of 128 lines of 16 bytes each, organised as four 32-bit longwords per line. It also has one staging line buffer that receives every line burst from memory. A fetch looks in the staging buffer and in the line store during the same cycle. A hit returns its data combinationally in the cycle the request is presented. A miss starts a memory transaction.

A burst does not write the line store directly. The new line stays in the staging buffer, which carries a recency flag. The buffered line is copied into the store at the following burst miss, and only if all four longwords arrived, the line was cacheable and the flag is still set. Any store hit at the buffer's line index clears the flag. In the narrow-index setting the line index takes six address bits instead of seven.

Two configuration inputs choose the operating mode. The first switches caching on or off. The second lets noncacheable code be fetched in line bursts that are served from the staging buffer but never kept in the store. When no burst is used, a single memory access is issued, and its size is a 16-bit word when fetch address bit 1 is set.

Top module: `icache_stage_ctrl`

## Requirements
- R1: After reset, fetch_ready and mem_req are low, and the first cacheable fetch goes to memory.
- R2: A fetch is a cacheable miss when cache_on=1, cacheable=1 and neither the staging buffer nor the store hits. It issues a burst (mem_burst=1) of four acknowledged beats at the line base (fetch address with bits [3:0] cleared), in ascending longword order. fetch_ready is held low until the beat holding the requested longword (address bits [3:2]) arrives, so ready comes with beat number bits[3:2]+1, and fetch_data carries that beat's data.
- R3: Once a burst has completed, fetches to any longword of that line hit in the staging buffer with no memory access and return the right longword.
- R4: A store hit whose line index equals the staging buffer's index clears the recency flag. The buffered line is then not copied at the next miss, and a later fetch of it goes to memory.
- R5: When a burst miss occurs while the staging buffer holds a complete cacheable line with its flag set, that line is copied into the store. Later fetches to it hit with no memory access.
- R6: The line index is address bits [10:4] when split_idx=0 and bits [9:4] when split_idx=1. The tag is address bits [ADDR_W-1:10] in both settings.
- R7: With cache_on=0, every fetch is a single memory access (mem_burst=0), repeated fetches of the same address go to memory each time, and burst_on has no effect.
- R8: With cache_on=1, burst_on=0 and cacheable=0, every fetch is a single memory access and is never served from the staging buffer.
- R9: With cache_on=1, burst_on=1 and cacheable=0, a fetch is burst into the staging buffer and later fetches of that line hit there. The line is never copied into the store: after a later miss, a cacheable fetch of it goes to memory.
- R10: A single access has mem_size=1 (16-bit word) when fetch address bit 1 is 1 and mem_size=0 (longword) otherwise. mem_addr carries the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_on | input | 1 | Caching enable |
| burst_on | input | 1 | Noncacheable line bursts into staging buffer enable |
| split_idx | input | 1 | Use the six-bit line index |
| fetch_valid | input | 1 | Fetch request, held until fetch_ready |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| cacheable | input | 1 | Attribute of the fetch address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Longword (or word access data) returned |
| mem_req | output | 1 | Memory transaction in progress |
| mem_burst | output | 1 | Transaction is a four-beat line burst |
| mem_size | output | 1 | Single access is a 16-bit word |
| mem_addr | output | ADDR_W | Transaction address (line base for bursts) |
| mem_ack | input | 1 | Memory beat delivered |
| mem_data | input | 32 | Memory beat data |

## Verification
Two functions can share one cycle. A store hit can clear the recency flag in the same cycle that decides the flag's later effect, and a burst miss copies the staging buffer out while the same buffer is reloaded. Both are provoked with two addresses at one line index, whose tags differ in bit 10 or bit 11, and the index setting decides whether they collide. The result is judged at the ports: the copy must happen exactly when the flag survives, so a later fetch either completes with zero memory beats or needs a fresh burst.

// File: rtl/icache_stage_ctrl.sv
module icache_stage_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_on,
  input  logic              burst_on,
  input  logic              split_idx,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cacheable,
  output logic              fetch_ready,
  output logic [31:0]       fetch_data,
  output logic              mem_req,
  output logic              mem_burst,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_data
);
  localparam int IDX_W = 7;
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - 10;

  typedef enum logic [1:0] {S_IDLE, S_SINGLE, S_BURST} st_t;
  st_t state;

  logic [TAG_W-1:0] st_tag   [LINES];
  logic [31:0]      st_data  [LINES][4];
  logic [LINES-1:0] st_valid;

  logic [TAG_W-1:0] fb_tag;
  logic [IDX_W-1:0] fb_idx;
  logic [31:0]      fb_data [4];
  logic [3:0]       fb_vmask;
  logic             fb_mru, fb_cache;
  logic [1:0]       beat, want;

  wire [IDX_W-1:0] idx  = split_idx ? {1'b0, fetch_addr[9:4]} : fetch_addr[10:4];
  wire [TAG_W-1:0] tag  = fetch_addr[ADDR_W-1:10];
  wire [1:0]       wsel = fetch_addr[3:2];

  wire use_fb  = cache_on && (cacheable || burst_on);
  wire use_st  = cache_on && cacheable;
  wire fb_hit  = use_fb && fb_tag == tag && fb_idx == idx && fb_vmask[wsel] && (fb_mru || !fb_cache);
  wire st_hit  = use_st && st_valid[idx] && st_tag[idx] == tag;
  wire req_now = state == S_IDLE && fetch_valid;
  wire miss    = req_now && !fb_hit && !st_hit;
  wire go_bst  = miss && use_fb;
  wire go_sgl  = miss && !use_fb;
  wire commit  = go_bst && fb_cache && fb_mru && (&fb_vmask);
  wire clr_mru = req_now && !fb_hit && st_hit && fb_idx == idx;
  wire last    = state == S_BURST && mem_ack && beat == 2'd3;

  assign mem_req   = state != S_IDLE;
  assign mem_burst = state == S_BURST;

  assign fetch_ready = (req_now && (fb_hit || st_hit))
                    || (state == S_BURST && mem_ack && beat == want)
                    || (state == S_SINGLE && mem_ack);
  assign fetch_data  = state != S_IDLE ? mem_data :
                       fb_hit ? fb_data[wsel] : st_data[idx][wsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      beat     <= '0;
      want     <= '0;
      mem_size <= 1'b0;
      mem_addr <= '0;
      fb_tag   <= '0;
      fb_idx   <= '0;
      fb_vmask <= '0;
      fb_mru   <= 1'b0;
      fb_cache <= 1'b0;
      st_valid <= '0;
    end else begin
      if (commit) st_valid[fb_idx] <= 1'b1;
      if (clr_mru) fb_mru <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go_sgl) begin
            state    <= S_SINGLE;
            mem_addr <= fetch_addr;
            mem_size <= fetch_addr[1];
          end else if (go_bst) begin
            state    <= S_BURST;
            mem_addr <= {fetch_addr[ADDR_W-1:4], 4'h0};
            mem_size <= 1'b0;
            beat     <= '0;
            want     <= wsel;
            fb_tag   <= tag;
            fb_idx   <= idx;
            fb_cache <= cacheable;
            fb_vmask <= '0;
            fb_mru   <= 1'b1;
          end
        end
        S_SINGLE: if (mem_ack) state <= S_IDLE;
        S_BURST: if (mem_ack) begin
          fb_vmask[beat] <= 1'b1;
          beat <= beat + 2'd1;
          if (last) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_BURST && mem_ack) fb_data[beat] <= mem_data;
    if (commit) begin
      st_tag[fb_idx] <= fb_tag;
      for (int w = 0; w < 4; w++) st_data[fb_idx][w] <= fb_data[w];
    end
  end

  assert_burst_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_bst |=> mem_burst && fb_mru && fb_vmask == 4'h0 && mem_addr[3:0] == 4'h0);
  assert_bypass_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_now && !cache_on) |=> !mem_burst);
  assert_no_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_now && cache_on && !burst_on && !cacheable) |-> !fetch_ready);
  assert_nc_never_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_now && !fb_cache && go_bst) |=> $stable(st_valid));
  assert_ready_with_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && state != S_IDLE) |-> mem_ack);
  assert_burst_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !mem_req && fb_vmask == 4'hF);
  assert_word_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_sgl |=> mem_size == $past(fetch_addr[1]));
endmodule

// File: tb/test_icache_stage_ctrl.sv
module test_icache_stage_ctrl;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  logic cache_on = 0, burst_on = 0, split_idx = 0, fetch_valid = 0, cacheable = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic fetch_ready, mem_req, mem_burst, mem_size, mem_ack = 0;
  logic [31:0] fetch_data, mem_data = '0;
  logic [AW-1:0] mem_addr;

  icache_stage_ctrl #(.ADDR_W(AW)) i_icache_stage_ctrl (
    .clk, .rst_n, .cache_on, .burst_on, .split_idx, .fetch_valid, .fetch_addr,
    .cacheable, .fetch_ready, .fetch_data, .mem_req, .mem_burst, .mem_size,
    .mem_addr, .mem_ack, .mem_data);

  always #5 clk = ~clk;

  int errors = 0, checks = 0, total_acks = 0, rbeat = 0;
  logic seen_burst, seen_size;
  logic [AW-1:0] seen_addr;
  bit done = 0;

  function automatic logic [31:0] memval(logic [AW-1:0] a);
    logic [15:0] al = 16'(a) & 16'hFFFC;
    return {al ^ 16'h5A5A, ~al};
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (rbeat == 0) begin
        seen_burst = mem_burst; seen_size = mem_size; seen_addr = mem_addr;
      end
      mem_ack = 1;
      mem_data = memval(mem_addr + AW'(4 * rbeat));
      total_acks++;
      rbeat = (mem_burst && rbeat < 3) ? rbeat + 1 : 0;
    end else begin
      mem_ack = 0; rbeat = 0;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; fetch_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  int r_acks, r_total;
  logic [31:0] r_data;
  task automatic fetch(logic [AW-1:0] a, logic cbl);
    int start;
    @(negedge clk);
    fetch_addr = a; cacheable = cbl; fetch_valid = 1; start = total_acks;
    #1;
    while (!fetch_ready) begin @(negedge clk); #1; end
    r_data = fetch_data; r_acks = total_acks - start;
    @(posedge clk); #1 fetch_valid = 0;
    @(negedge clk); #1;
    while (mem_req) begin @(negedge clk); #1; end
    r_total = total_acks - start;
  endtask

  localparam logic [AW-1:0] X = 16'h0050, Y = 16'h0450, X2 = 16'h0850, Z = 16'h0090;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    cache_on = 1; burst_on = 0; split_idx = 0;
    #1;
    chk("R1", "ready after reset", fetch_ready, 0);
    chk("R1", "mem_req after reset", mem_req, 0);
    fetch(X + 8, 1);
    chk("R1", "first fetch misses", r_total, 4);
    chk("R2", "burst flag", seen_burst, 1);
    chk("R2", "burst base", seen_addr, X);
    chk("R2", "beats before ready", r_acks, 3);
    chk("R2", "miss data", r_data, memval(X + 8));
    for (int w = 0; w < 4; w++) begin
      fetch(X + AW'(4 * w), 1);
      chk("R3", "buffer hit acks", r_total, 0);
      chk("R3", "buffer hit data", r_data, memval(X + AW'(4 * w)));
    end
    fetch(Y + 4, 1);
    chk("R2", "beats before ready w1", r_acks, 2);
    for (int w = 0; w < 4; w++) begin
      fetch(X + AW'(4 * w), 1);
      chk("R5", "committed line hit acks", r_total, 0);
      chk("R5", "committed line data", r_data, memval(X + AW'(4 * w)));
    end
    fetch(Y + 12, 1);
    chk("R6", "full index keeps flag", r_total, 0);

    do_reset(); split_idx = 1;
    fetch(X, 1); fetch(Y, 1); fetch(X + 4, 1);
    chk("R6", "split index commit hit", r_total, 0);
    fetch(Y, 1);
    chk("R6", "split index clears flag", r_total, 4);

    do_reset(); split_idx = 0;
    fetch(X, 1); fetch(X2, 1); fetch(X, 1);
    chk("R4", "store hit", r_total, 0);
    fetch(Z, 1); fetch(X2 + 4, 1);
    chk("R4", "cleared line not kept", r_total, 4);

    do_reset(); cache_on = 0; burst_on = 1;
    for (int k = 0; k < 2; k++) begin
      fetch(X + 4, 1);
      chk("R7", "bypass single", r_total, 1);
      chk("R7", "bypass no burst", seen_burst, 0);
      chk("R7", "bypass data", r_data, memval(X + 4));
    end
    for (int h = 0; h < 4; h++) begin
      fetch(X + AW'(2 * h), 1);
      chk("R10", "size from bit1", seen_size, h % 2);
      chk("R10", "single address", seen_addr, X + AW'(2 * h));
    end

    do_reset(); cache_on = 1; burst_on = 0;
    for (int k = 0; k < 2; k++) begin
      fetch(X, 0);
      chk("R8", "nc single", r_total, 1);
      chk("R8", "nc no burst", seen_burst, 0);
    end

    do_reset(); burst_on = 1;
    fetch(X + 4, 0);
    chk("R9", "nc burst", seen_burst, 1);
    chk("R9", "nc burst beats", r_total, 4);
    fetch(X + 12, 0);
    chk("R9", "nc buffer hit", r_total, 0);
    chk("R9", "nc buffer data", r_data, memval(X + 12));
    fetch(Z, 1);
    fetch(X, 1);
    chk("R9", "nc line never kept", r_total, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule